// File: doc/BRIEF.md
# Programmable Three-Axis Loop Index Generator

This block turns a 32-bit shape descriptor into a stream of element indices, one per accepted step. Three axis counters (x, y, z) are nested in an order chosen at load time, each axis may count up or down, and the linear index is formed from the three positions and the effective axis sizes, plus a small constant offset. When the outermost loop finishes, the walk restarts at its first position and runs on without end.

A load strobe captures the descriptor together with a nesting order, per-axis direction bits and an indexed-variant flag, then puts every counter on its start value. After that the consumer takes indices with a valid/ready handshake. Two decode variants matter here: the plain matrix mode, and a collapse mode (mode value 3) that drops the third dimension and moves the first two size fields up one axis. That collapse mode also carries a triangle marker, which masks the end flags of any axis of size one.

Top module: `loop3_index_gen`

## Requirements
- R1: Descriptor fields, in LSB0 bit numbers: x size `shape_i[31:26]`, y size `[25:20]`, z size `[19:14]`, skip `[10:9]`, offset `[7:4]`, mode `[3:2]`. Each size field holds the size minus one. In modes 0 to 2 the effective limits are x = xfield+1, y = yfield+1 and z = zfield+1, and each axis position stays below its limit.
- R2: In mode 3 the x limit is 1, the y limit is xfield+1 and the z limit is yfield+1. The z size field then has no effect and the x position stays at 0.
- R3: In modes 0 to 2, `indexed_i` high at load forces the z limit to 1.
- R4: `inv_i` bit a (0 = x, 1 = y, 2 = z) makes that axis start at limit-1 and count down to 0. Otherwise it starts at 0 and counts up to limit-1.
- R5: `order_i[1:0]` names the innermost axis, `[3:2]` the middle one and `[5:4]` the outermost (axis ids 0 = x, 1 = y, 2 = z). An axis advances only when every axis inside it is on its last value.
- R6: An order that repeats an axis id or uses id 3 behaves as innermost x, middle y, outermost z.
- R7: `idx_o` = (x + y*xlim + z*xlim*ylim + offset) mod 256, using the effective limits.
- R8: `end_o` bit a is high when axis a is on its last value. In triangle mode (mode 3 with skip bit `shape_i[10]` set), the bit of any axis whose limit is 1 is held low.
- R9: The counters advance only in a cycle where `idx_valid_o` and `idx_ready_i` are both high. Otherwise `idx_o` and `end_o` hold.
- R10: `load_i` takes priority over a step in the same cycle. The next index is the start position, and `idx_valid_o` is high from the cycle after the first load.
- R11: When the outermost axis leaves its last value, all axes return to their start values and the walk continues.
- R12: After reset, `idx_valid_o` is 0, `idx_o` is 0 and `end_o` is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture descriptor, order, direction and variant; restart the walk |
| shape_i | input | 32 | Shape descriptor |
| order_i | input | 6 | Nesting order: three 2-bit axis ids, innermost in the low bits |
| inv_i | input | 3 | Per-axis count-down bits (bit 0 x, bit 1 y, bit 2 z) |
| indexed_i | input | 1 | Indexed variant: z limit forced to 1 |
| idx_ready_i | input | 1 | Consumer accepts the current index |
| idx_valid_o | output | 1 | An index is available (a descriptor has been loaded) |
| idx_o | output | 8 | Current linear index |
| end_o | output | 3 | Per-axis last-value flags |

## Verification
On every cycle the assertions check four things: each axis position stays inside its registered limit, a counter holds when it is neither loaded nor advanced, the x position stays at zero under the collapse mode, and the x end flag is masked in triangle mode. Only the directed scenarios can show the real walk order. That covers the permuted nesting and its fallback for an invalid order, the count-down start values, wraparound at the end of the outermost loop, the offset with 8-bit truncation, and load taking priority over a step. The bench compares each of these against its own step model.

// File: rtl/loop3_pkg.sv
// Shared widths, descriptor field positions (LSB0) and types for the
// three-axis loop index generator. Assumes a 32-bit descriptor.
package loop3_pkg;
    localparam int NAX      = 3;
    localparam int SZ_W     = 6;
    localparam int LIM_W    = SZ_W + 1;
    localparam int OFS_W    = 4;
    localparam int IDX_W    = 8;
    localparam int AXID_W   = 2;
    localparam int DESC_W   = 32;
    localparam int MODE_W   = 2;
    localparam int XSZ_LO   = 26;
    localparam int YSZ_LO   = 20;
    localparam int ZSZ_LO   = 14;
    localparam int SKIP_TRI = 10;
    localparam int OFS_LO   = 4;
    localparam int MODE_LO  = 2;
    localparam logic [MODE_W-1:0] MODE_COLLAPSE = 2'b11;

    typedef logic [LIM_W-1:0]  lim_t;
    typedef logic [SZ_W-1:0]   pos_t;
    typedef logic [AXID_W-1:0] axid_t;
endpackage

// File: rtl/loop3_decode.sv
// Combinational descriptor decode: effective per-axis limits, offset,
// collapse and triangle markers. Assumes sizes are stored minus one.
module loop3_decode
    import loop3_pkg::*;
(
    input  logic [DESC_W-1:0]   desc_i,
    input  logic                indexed_i,
    output lim_t [NAX-1:0]      lim_o,
    output logic [OFS_W-1:0]    ofs_o,
    output logic                collapse_o,
    output logic                tri_o
);
    logic [SZ_W-1:0]   xf, yf, zf;
    logic [MODE_W-1:0] mode;
    logic              unused_bits;

    assign xf   = desc_i[XSZ_LO +: SZ_W];
    assign yf   = desc_i[YSZ_LO +: SZ_W];
    assign zf   = desc_i[ZSZ_LO +: SZ_W];
    assign mode = desc_i[MODE_LO +: MODE_W];
    assign unused_bits = ^{desc_i[13:11], desc_i[9:8], desc_i[1:0]};

    // Pick limits per mode; collapse drops the third dimension.
    always_comb begin
        collapse_o = (mode == MODE_COLLAPSE);
        tri_o      = collapse_o & desc_i[SKIP_TRI];
        ofs_o      = desc_i[OFS_LO +: OFS_W];
        if (collapse_o) begin
            lim_o[0] = LIM_W'(1);
            lim_o[1] = LIM_W'(xf) + LIM_W'(1);
            lim_o[2] = LIM_W'(yf) + LIM_W'(1);
        end else begin
            lim_o[0] = LIM_W'(xf) + LIM_W'(1);
            lim_o[1] = LIM_W'(yf) + LIM_W'(1);
            lim_o[2] = indexed_i ? LIM_W'(1) : LIM_W'(zf) + LIM_W'(1);
        end
    end
endmodule

// File: rtl/loop3_axis.sv
// One axis counter. Captures its limit and direction on load and jumps to
// its start value; on advance it steps by one or wraps to the start.
// Assumes the loaded limit is between 1 and 2**SZ_W.
module loop3_axis
    import loop3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_i,
    input  lim_t ld_lim_i,
    input  logic ld_inv_i,
    input  logic adv_i,
    output pos_t pos_o,
    output lim_t lim_o,
    output logic last_o
);
    pos_t pos_q;
    lim_t lim_q;
    logic inv_q;
    pos_t start;

    assign start  = inv_q ? SZ_W'(lim_q - LIM_W'(1)) : '0;
    assign last_o = inv_q ? (pos_q == '0) : ({1'b0, pos_q} == lim_q - LIM_W'(1));
    assign pos_o  = pos_q;
    assign lim_o  = lim_q;

    // Position, limit and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            lim_q <= LIM_W'(1);
            inv_q <= 1'b0;
        end else if (ld_i) begin
            lim_q <= ld_lim_i;
            inv_q <= ld_inv_i;
            pos_q <= ld_inv_i ? SZ_W'(ld_lim_i - LIM_W'(1)) : '0;
        end else if (adv_i) begin
            if (last_o)     pos_q <= start;
            else if (inv_q) pos_q <= pos_q - SZ_W'(1);
            else            pos_q <= pos_q + SZ_W'(1);
        end
    end

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, pos_q} < lim_q);
    // R9
    axis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !adv_i) |=> $stable(pos_q));
endmodule

// File: rtl/loop3_order.sv
// Nesting-order control. Validates and stores the order at load (falling
// back to x-inner, z-outer when an id repeats or is out of range) and
// ripples the step carry from the innermost to the outermost axis.
module loop3_order
    import loop3_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_i,
    input  logic [NAX*AXID_W-1:0]   ord_i,
    input  logic                    step_i,
    input  logic [NAX-1:0]          last_i,
    output logic [NAX-1:0]          adv_o
);
    axid_t ax_at_q [NAX];
    axid_t ax_at_d [NAX];
    logic  ord_ok;

    // Check the requested permutation for range and uniqueness.
    always_comb begin
        ord_ok = 1'b1;
        for (int r = 0; r < NAX; r++) begin
            if (int'(ord_i[r*AXID_W +: AXID_W]) >= NAX) ord_ok = 1'b0;
            for (int s = r + 1; s < NAX; s++)
                if (ord_i[r*AXID_W +: AXID_W] == ord_i[s*AXID_W +: AXID_W])
                    ord_ok = 1'b0;
        end
        for (int r = 0; r < NAX; r++)
            ax_at_d[r] = ord_ok ? ord_i[r*AXID_W +: AXID_W] : axid_t'(r);
    end

    // Hold the resolved order (rank -> axis id).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NAX; r++) ax_at_q[r] <= axid_t'(r);
        end else if (ld_i) begin
            for (int r = 0; r < NAX; r++) ax_at_q[r] <= ax_at_d[r];
        end
    end

    // Carry ripple: each rank advances when all inner ranks are last.
    always_comb begin
        logic carry;
        carry = step_i;
        adv_o = '0;
        for (int r = 0; r < NAX; r++) begin
            adv_o[ax_at_q[r]] = carry;
            carry = carry & last_i[ax_at_q[r]];
        end
    end
endmodule

// File: rtl/loop3_index_gen.sv
// Top of the three-axis loop index generator. Captures the descriptor on
// load, runs one counter per axis under the loaded nesting order and forms
// the linear index with offset. Assumes a single consumer on the handshake.
module loop3_index_gen
    import loop3_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [DESC_W-1:0]     shape_i,
    input  logic [NAX*AXID_W-1:0] order_i,
    input  logic [NAX-1:0]        inv_i,
    input  logic                  indexed_i,
    input  logic                  idx_ready_i,
    output logic                  idx_valid_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic [NAX-1:0]        end_o
);
    localparam int WIDE_W = 2 * LIM_W + SZ_W + 2;

    lim_t [NAX-1:0]   dec_lim;
    logic [OFS_W-1:0] dec_ofs;
    logic             dec_coll, dec_tri;
    logic [OFS_W-1:0] ofs_q;
    logic             coll_q, tri_q, loaded_q;
    logic             step;
    logic [NAX-1:0]   adv, last;
    pos_t [NAX-1:0]   pos;
    lim_t [NAX-1:0]   lim;
    logic [WIDE_W-1:0] idx_wide;

    loop3_decode u_dec (
        .desc_i(shape_i), .indexed_i(indexed_i), .lim_o(dec_lim),
        .ofs_o(dec_ofs), .collapse_o(dec_coll), .tri_o(dec_tri)
    );

    assign step = loaded_q & idx_ready_i & ~load_i;

    loop3_order u_ord (
        .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ord_i(order_i),
        .step_i(step), .last_i(last), .adv_o(adv)
    );

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        loop3_axis u_axis (
            .clk(clk), .rst_n(rst_n), .ld_i(load_i), .ld_lim_i(dec_lim[a]),
            .ld_inv_i(inv_i[a]), .adv_i(adv[a]), .pos_o(pos[a]),
            .lim_o(lim[a]), .last_o(last[a])
        );
        // Mask end flags of unit axes in triangle mode.
        assign end_o[a] = last[a] & ~(tri_q && lim[a] == LIM_W'(1));
    end

    // Mode markers, offset and load status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q    <= '0;
            coll_q   <= 1'b0;
            tri_q    <= 1'b0;
            loaded_q <= 1'b0;
        end else if (load_i) begin
            ofs_q    <= dec_ofs;
            coll_q   <= dec_coll;
            tri_q    <= dec_tri;
            loaded_q <= 1'b1;
        end
    end

    // Linear index from positions, limits and offset, truncated.
    always_comb begin
        idx_wide = WIDE_W'(pos[0])
                 + WIDE_W'(pos[1]) * WIDE_W'(lim[0])
                 + WIDE_W'(pos[2]) * WIDE_W'(lim[0]) * WIDE_W'(lim[1])
                 + WIDE_W'(ofs_q);
        idx_o = idx_wide[IDX_W-1:0];
    end

    assign idx_valid_o = loaded_q;

    // R2
    collapse_xfix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coll_q |-> (pos[0] == '0));
    // R8
    tri_xflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tri_q |-> !end_o[0]);
    // R10
    load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> idx_valid_o);
endmodule

// File: tb/loop3_index_gen_tb.sv
module loop3_index_gen_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, load = 1'b0, ready = 1'b0, indexed = 1'b0;
    logic [31:0] shape = '0;
    logic [5:0]  order = 6'b100100;
    logic [2:0]  inv = '0;
    logic        vld;
    logic [7:0]  idx;
    logic [2:0]  ends;

    int checks = 0, errors = 0;
    bit done = 0;

    int m_lim[3], m_pos[3], m_ax[3], m_off;
    bit m_inv[3], m_tri;

    loop3_index_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .shape_i(shape),
        .order_i(order), .inv_i(inv), .indexed_i(indexed),
        .idx_ready_i(ready), .idx_valid_o(vld), .idx_o(idx), .end_o(ends)
    );

    function automatic logic [31:0] mk(int xs, int ys, int zs, int skip, int off, int mode);
        return {6'(xs), 6'(ys), 6'(zs), 1'b0, 2'b00, 2'(skip), 1'b0, 4'(off), 2'(mode), 2'b00};
    endfunction

    function automatic logic [5:0] ord(int inner, int mid, int outer);
        return {2'(outer), 2'(mid), 2'(inner)};
    endfunction

    function automatic bit m_last(int a);
        return m_inv[a] ? (m_pos[a] == 0) : (m_pos[a] == m_lim[a] - 1);
    endfunction

    function automatic int m_start(int a);
        return m_inv[a] ? m_lim[a] - 1 : 0;
    endfunction

    function automatic int m_idx();
        return (m_pos[0] + m_pos[1] * m_lim[0] + m_pos[2] * m_lim[0] * m_lim[1] + m_off) % 256;
    endfunction

    function automatic int m_end();
        int e = 0;
        for (int a = 0; a < 3; a++)
            if (m_last(a) && !(m_tri && m_lim[a] == 1)) e |= (1 << a);
        return e;
    endfunction

    task automatic m_load(logic [31:0] d, logic [5:0] o, logic [2:0] iv, bit ix);
        int xs = int'(d[31:26]), ys = int'(d[25:20]), zs = int'(d[19:14]);
        int md = int'(d[3:2]);
        int e[3];
        bit ok = 1;
        if (md == 3) begin
            m_lim[0] = 1; m_lim[1] = xs + 1; m_lim[2] = ys + 1;
        end else begin
            m_lim[0] = xs + 1; m_lim[1] = ys + 1; m_lim[2] = ix ? 1 : zs + 1;
        end
        m_tri = (md == 3) && d[10];
        m_off = int'(d[7:4]);
        for (int r = 0; r < 3; r++) e[r] = int'(o[2*r +: 2]);
        for (int r = 0; r < 3; r++) if (e[r] > 2) ok = 0;
        if (e[0] == e[1] || e[0] == e[2] || e[1] == e[2]) ok = 0;
        for (int r = 0; r < 3; r++) m_ax[r] = ok ? e[r] : r;
        for (int a = 0; a < 3; a++) begin
            m_inv[a] = iv[a];
            m_pos[a] = m_start(a);
        end
    endtask

    task automatic m_step();
        bit carry = 1;
        for (int r = 0; r < 3; r++) begin
            int a = m_ax[r];
            if (carry) begin
                if (m_last(a)) m_pos[a] = m_start(a);
                else begin
                    m_pos[a] = m_inv[a] ? m_pos[a] - 1 : m_pos[a] + 1;
                    carry = 0;
                end
            end
        end
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag);
        chk(int'(idx) == m_idx(), {tag, " index"}, int'(idx), m_idx());
        chk(int'(ends) == m_end(), {tag, " end flags"}, int'(ends), m_end());
    endtask

    task automatic ld(logic [31:0] d, logic [5:0] o, logic [2:0] iv, bit ix);
        @(negedge clk);
        shape = d; order = o; inv = iv; indexed = ix; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_load(d, o, iv, ix);
    endtask

    task automatic stp();
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        m_step();
    endtask

    task automatic walk(int n, string tag);
        for (int i = 0; i < n; i++) begin
            check_out(tag);
            stp();
        end
        check_out(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(vld == 1'b0, "R12 valid", int'(vld), 0);
        chk(idx == 8'd0, "R12 index", int'(idx), 0);
        chk(ends == 3'b111, "R12 end flags", int'(ends), 7);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        chk(vld == 1'b0, "R10 valid before load", int'(vld), 0);
    endtask

    task automatic t_plain();
        ld(mk(2, 1, 1, 0, 0, 0), ord(0, 1, 2), 3'b000, 1'b0);
        chk(vld == 1'b1, "R10 valid after load", int'(vld), 1);
        chk(idx == 8'd0, "R10 start index", int'(idx), 0);
        walk(13, "R1 R11 plain walk");
        chk(idx == 8'd1, "R11 wrapped index", int'(idx), 1);
    endtask

    task automatic t_order();
        ld(mk(1, 2, 1, 0, 5, 0), ord(2, 0, 1), 3'b000, 1'b0);
        stp();
        chk(idx == 8'd11, "R5 z innermost first step", int'(idx), 11);
        walk(14, "R5 permuted order");
    endtask

    task automatic t_invert();
        ld(mk(2, 1, 2, 0, 3, 0), ord(0, 1, 2), 3'b101, 1'b0);
        chk(idx == 8'd17, "R4 count-down start", int'(idx), 17);
        walk(20, "R4 count-down walk");
    endtask

    task automatic t_badorder();
        ld(mk(1, 1, 1, 0, 0, 0), ord(0, 0, 1), 3'b000, 1'b0);
        walk(9, "R6 repeated id");
        ld(mk(1, 2, 1, 0, 0, 0), ord(3, 1, 0), 3'b000, 1'b0);
        walk(13, "R6 id three");
    endtask

    task automatic t_collapse();
        ld(mk(3, 2, 5, 0, 0, 3), ord(0, 1, 2), 3'b000, 1'b0);
        chk(ends[0] == 1'b1, "R8 x flag without triangle", int'(ends[0]), 1);
        walk(14, "R2 collapse walk");
        ld(mk(3, 2, 5, 2, 0, 3), ord(0, 1, 2), 3'b001, 1'b0);
        chk(ends[0] == 1'b0, "R8 triangle x flag", int'(ends[0]), 0);
        walk(14, "R8 triangle walk");
    endtask

    task automatic t_indexed();
        ld(mk(1, 1, 3, 0, 0, 0), ord(0, 1, 2), 3'b000, 1'b1);
        walk(6, "R3 indexed walk");
    endtask

    task automatic t_hold();
        ld(mk(3, 3, 0, 0, 1, 0), ord(0, 1, 2), 3'b000, 1'b0);
        stp();
        stp();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_out("R9 hold without ready");
        end
    endtask

    task automatic t_loadprio();
        logic [31:0] d;
        ld(mk(3, 3, 0, 0, 0, 0), ord(0, 1, 2), 3'b000, 1'b0);
        stp(); stp(); stp();
        d = mk(2, 2, 0, 0, 7, 0);
        @(negedge clk);
        shape = d; order = ord(1, 0, 2); inv = 3'b010; indexed = 1'b0;
        load = 1'b1; ready = 1'b1;
        @(negedge clk);
        load = 1'b0; ready = 1'b0;
        m_load(d, ord(1, 0, 2), 3'b010, 1'b0);
        chk(idx == 8'd13, "R10 load over step", int'(idx), 13);
        walk(4, "R10 after priority load");
    endtask

    task automatic t_trunc();
        ld(mk(63, 63, 0, 0, 15, 0), ord(0, 1, 2), 3'b011, 1'b0);
        chk(idx == 8'd14, "R7 truncated index", int'(idx), 14);
        walk(3, "R7 large walk");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_order();
        t_invert();
        t_badorder();
        t_collapse();
        t_indexed();
        t_hold();
        t_loadprio();
        t_trunc();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule